// File: doc/BRIEF.md
# Control Register Write Side-Effect Unit

This unit holds the paging and mode control registers of a processor core (CR0, CR2, CR3, CR4, CR8, the extended feature register), the code and stack segment attribute words, and eight segment base registers with their effective bases. Each write through its single write port is checked against the previous contents. Toggled bits then produce the architectural side effects. Turning paging on or off with long mode enabled switches long mode active. Changes to paging configuration request a full flush of the instruction and data translation buffers. Every CR3 write requests a non-global flush. A change of the code segment long-mode attribute either zeroes or restores the effective bases of the four legacy segments. Writes that change the operating mode strobe the mode decoder so that it recomputes.

All side-effect outputs are combinational single-cycle pulses in the cycle the write is presented. Register state updates on the following clock edge. The read port is combinational. An index that is not an architectural register raises `err`. Such a write changes nothing, and such a read returns zero. `flush_all` and `flush_nonglobal` each apply to both translation buffers at once. The data width parameter `XLEN` must be at least 32.

Top module: `cr_side_effect_unit`

## Requirements
- R1: Register index map (6-bit): 0x00+n is CRn, with only CR0, CR2, CR3, CR4 and CR8 legal. 0x10 is the extended feature register, with long-mode-enable at bit 8 and long-mode-active at bit 10. 0x11 is the code segment attribute and 0x12 the stack segment attribute. 0x18+i is the base of segment i, and 0x20+i is its effective base, which is read-only. Segments are ordered 0 ES, 1 CS, 2 SS, 3 DS, 4 FS, 5 GS, 6 TR, 7 IDTR. A CR0 write that flips CR0 bit 31 (paging) while long-mode-enable is 1 sets long-mode-active to the new bit 31 value. With long-mode-enable at 0, long-mode-active is left as it is.
- R2: A CR0 write that flips bit 31 pulses `flush_all` in that same cycle. A CR0 write that leaves bit 31 unchanged does not pulse it.
- R3: CR0 bit 4 always reads 1, so CR0 reads 0x10 after reset and the written value with bit 4 set after any write.
- R4: Every CR3 write pulses `flush_nonglobal` in that cycle, whatever the data, and does not pulse `flush_all`.
- R5: A CR4 write that flips any of bits 4, 5 or 7 pulses `flush_all`. A write that flips only other bits does not.
- R6: A code segment attribute write that flips bit 9 (the long-mode attribute) from 0 to 1 clears the effective bases of segments 0 to 3. A flip from 1 to 0 reloads each of them from its base. A write that leaves bit 9 unchanged leaves them alone.
- R7: A base write to segments 0 to 3 also updates that segment's effective base only outside 64-bit mode, where 64-bit mode means long-mode-active and attribute bit 9 are both 1. Base writes to segments 4 to 7 always update the effective base.
- R8: `mode_recompute` pulses on writes to CR0, the code segment attribute or the stack segment attribute, and on no other write.
- R9: An illegal index raises `err` in the cycle it is presented. This covers a write to any index outside the legal write set, or a read of any index that is neither legal to write nor an effective base. Such a write changes no register and raises no flush or recompute. Such a read returns zero.
- R10: After reset every register reads zero except CR0, and each legal register reads back its last written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request this cycle |
| wr_idx | input | 6 | Register index of the write |
| wr_data | input | XLEN | Value to write |
| rd_en | input | 1 | Read request, used for error reporting |
| rd_idx | input | 6 | Register index of the read |
| rd_data | output | XLEN | Combinational read data, zero when illegal |
| err | output | 1 | Illegal read or write index this cycle |
| flush_all | output | 1 | Full flush of both translation buffers |
| flush_nonglobal | output | 1 | Non-global flush of both translation buffers |
| mode_recompute | output | 1 | Mode decoder recompute strobe |

## Verification
The assertions watch every cycle for several properties. Long-mode-active must follow paging after a flip with long mode enabled. A flush raised by a CR0 or CR4 write must really correspond to a flipped bit. CR0 bit 4 must never clear. Illegal writes must leave all state frozen and illegal reads must return zero. Legacy effective bases must hold in 64-bit mode and must clear when the long-mode attribute rises. Only the bench's scenarios show the absence of pulses on non-toggling writes, the reload of effective bases from bases changed while in 64-bit mode, and the full legality map across all 64 indexes.

// File: rtl/cr_unit_pkg.sv
package cr_unit_pkg;
  localparam int IDX_W  = 6;
  localparam int NSEG   = 8;
  localparam int NLEG   = 4;
  localparam int SEG_W  = $clog2(NSEG);

  localparam int CR0_ET  = 4;
  localparam int CR0_PG  = 31;
  localparam int CR4_PSE = 4;
  localparam int CR4_PAE = 5;
  localparam int CR4_PGE = 7;
  localparam int EF_LME  = 8;
  localparam int EF_LMA  = 10;
  localparam int AT_LONG = 9;

  localparam logic [IDX_W-1:0] IX_EFER  = 6'h10;
  localparam logic [IDX_W-1:0] IX_CSATR = 6'h11;
  localparam logic [IDX_W-1:0] IX_SSATR = 6'h12;
  localparam logic [IDX_W-1:0] IX_BASE  = 6'h18;
  localparam logic [IDX_W-1:0] IX_EFF   = 6'h20;

  typedef enum logic [2:0] {
    K_NONE, K_CR, K_EFER, K_CSATR, K_SSATR, K_BASE, K_EFF
  } idx_kind_e;

  function automatic idx_kind_e classify(input logic [IDX_W-1:0] idx);
    idx_kind_e k;
    k = K_NONE;
    if (idx[IDX_W-1:4] == '0) begin
      case (idx[3:0])
        4'd0, 4'd2, 4'd3, 4'd4, 4'd8: k = K_CR;
        default:                      k = K_NONE;
      endcase
    end else if (idx == IX_EFER)  k = K_EFER;
    else if (idx == IX_CSATR)     k = K_CSATR;
    else if (idx == IX_SSATR)     k = K_SSATR;
    else if (idx[IDX_W-1:SEG_W] == IX_BASE[IDX_W-1:SEG_W]) k = K_BASE;
    else if (idx[IDX_W-1:SEG_W] == IX_EFF[IDX_W-1:SEG_W])  k = K_EFF;
    return k;
  endfunction

  function automatic logic flipped(input logic old_b, input logic new_b);
    return old_b ^ new_b;
  endfunction

  function automatic logic pcfg_flipped(input logic [2:0] old_c, input logic [2:0] new_c);
    return |(old_c ^ new_c);
  endfunction

  function automatic logic in_64bit(input logic lma, input logic cs_long);
    return lma & cs_long;
  endfunction
endpackage

// File: rtl/cr_index_decode.sv
module cr_index_decode
  import cr_unit_pkg::*;
(
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output idx_kind_e        wr_kind,
  output idx_kind_e        rd_kind,
  output logic [3:0]       wr_cr,
  output logic [3:0]       rd_cr,
  output logic [SEG_W-1:0] wr_seg,
  output logic [SEG_W-1:0] rd_seg,
  output logic             wr_ok,
  output logic             rd_ok
);
  always_comb begin
    wr_kind = classify(wr_idx);
    rd_kind = classify(rd_idx);
    wr_cr   = wr_idx[3:0];
    rd_cr   = rd_idx[3:0];
    wr_seg  = wr_idx[SEG_W-1:0];
    rd_seg  = rd_idx[SEG_W-1:0];
    wr_ok   = (wr_kind != K_NONE) && (wr_kind != K_EFF);
    rd_ok   = (rd_kind != K_NONE);
  end
endmodule

// File: rtl/cr_event_gen.sv
module cr_event_gen
  import cr_unit_pkg::*;
(
  input  logic       wr_fire,
  input  idx_kind_e  wr_kind,
  input  logic [3:0] wr_cr,
  input  logic       old_pg,
  input  logic       new_pg,
  input  logic [2:0] old_pcfg,
  input  logic [2:0] new_pcfg,
  input  logic       lme,
  input  logic       old_long,
  input  logic       new_long,
  output logic       ev_cr0_wr,
  output logic       ev_pg_flip,
  output logic       ev_lma_upd,
  output logic       ev_flush_all,
  output logic       ev_flush_ng,
  output logic       ev_recompute,
  output logic       ev_long_on,
  output logic       ev_long_off
);
  logic cr_wr, cr4_wr, cs_wr, ss_wr, long_flip;

  always_comb begin
    cr_wr        = wr_fire && (wr_kind == K_CR);
    ev_cr0_wr    = cr_wr && (wr_cr == 4'd0);
    cr4_wr       = cr_wr && (wr_cr == 4'd4);
    cs_wr        = wr_fire && (wr_kind == K_CSATR);
    ss_wr        = wr_fire && (wr_kind == K_SSATR);
    ev_pg_flip   = ev_cr0_wr && flipped(old_pg, new_pg);
    ev_lma_upd   = ev_pg_flip && lme;
    ev_flush_all = ev_pg_flip || (cr4_wr && pcfg_flipped(old_pcfg, new_pcfg));
    ev_flush_ng  = cr_wr && (wr_cr == 4'd3);
    ev_recompute = ev_cr0_wr || cs_wr || ss_wr;
    long_flip    = cs_wr && flipped(old_long, new_long);
    ev_long_on   = long_flip && new_long;
    ev_long_off  = long_flip && !new_long;
  end
endmodule

// File: rtl/seg_base_bank.sv
module seg_base_bank
  import cr_unit_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       base_we,
  input  logic [SEG_W-1:0]           base_sel,
  input  logic [XLEN-1:0]            base_wdata,
  input  logic                       in64,
  input  logic                       zero_legacy,
  input  logic                       reload_legacy,
  output logic [NSEG-1:0][XLEN-1:0]  base_q,
  output logic [NSEG-1:0][XLEN-1:0]  eff_q
);
  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    logic hit;
    assign hit = base_we && (base_sel == SEG_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) base_q[i] <= '0;
      else if (hit) base_q[i] <= base_wdata;
    end

    if (i < NLEG) begin : g_legacy
      always_ff @(posedge clk) begin
        if (!rst_n)               eff_q[i] <= '0;
        else if (zero_legacy)     eff_q[i] <= '0;
        else if (reload_legacy)   eff_q[i] <= base_q[i];
        else if (hit && !in64)    eff_q[i] <= base_wdata;
      end

      AST_LEGACY_HELD_64: assert property (@(posedge clk) disable iff (!rst_n) (hit && in64 && !zero_legacy && !reload_legacy) |=> $stable(eff_q[i])); // R7
      AST_LEGACY_ZEROED: assert property (@(posedge clk) disable iff (!rst_n) zero_legacy |=> (eff_q[i] == '0)); // R6
    end else begin : g_always
      always_ff @(posedge clk) begin
        if (!rst_n)   eff_q[i] <= '0;
        else if (hit) eff_q[i] <= base_wdata;
      end

      AST_UPPER_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) hit |=> (eff_q[i] == base_q[i])); // R7
    end
  end
endmodule

// File: rtl/cr_side_effect_unit.sv
module cr_side_effect_unit
  import cr_unit_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [5:0]       wr_idx,
  input  logic [XLEN-1:0]  wr_data,
  input  logic             rd_en,
  input  logic [5:0]       rd_idx,
  output logic [XLEN-1:0]  rd_data,
  output logic             err,
  output logic             flush_all,
  output logic             flush_nonglobal,
  output logic             mode_recompute
);
  localparam logic [XLEN-1:0] CR0_RST = XLEN'(1) << CR0_ET;

  logic [XLEN-1:0] cr0_q, cr2_q, cr3_q, cr4_q, cr8_q, efer_q, csatr_q, ssatr_q;
  logic [NSEG-1:0][XLEN-1:0] base_q, eff_q;

  idx_kind_e        wr_kind, rd_kind;
  logic [3:0]       wr_cr, rd_cr;
  logic [SEG_W-1:0] wr_seg, rd_seg;
  logic             wr_ok, rd_ok, wr_fire, wr_bad, rd_bad;
  logic ev_cr0_wr, ev_pg_flip, ev_lma_upd, ev_flush_all, ev_flush_ng;
  logic ev_recompute, ev_long_on, ev_long_off;

  cr_index_decode u_dec (
    .wr_idx (wr_idx), .rd_idx (rd_idx),
    .wr_kind(wr_kind), .rd_kind(rd_kind),
    .wr_cr  (wr_cr),   .rd_cr  (rd_cr),
    .wr_seg (wr_seg),  .rd_seg (rd_seg),
    .wr_ok  (wr_ok),   .rd_ok  (rd_ok)
  );

  assign wr_fire = wr_en && wr_ok;
  assign wr_bad  = wr_en && !wr_ok;
  assign rd_bad  = rd_en && !rd_ok;

  cr_event_gen u_evt (
    .wr_fire     (wr_fire),
    .wr_kind     (wr_kind),
    .wr_cr       (wr_cr),
    .old_pg      (cr0_q[CR0_PG]),
    .new_pg      (wr_data[CR0_PG]),
    .old_pcfg    ({cr4_q[CR4_PGE], cr4_q[CR4_PAE], cr4_q[CR4_PSE]}),
    .new_pcfg    ({wr_data[CR4_PGE], wr_data[CR4_PAE], wr_data[CR4_PSE]}),
    .lme         (efer_q[EF_LME]),
    .old_long    (csatr_q[AT_LONG]),
    .new_long    (wr_data[AT_LONG]),
    .ev_cr0_wr   (ev_cr0_wr),
    .ev_pg_flip  (ev_pg_flip),
    .ev_lma_upd  (ev_lma_upd),
    .ev_flush_all(ev_flush_all),
    .ev_flush_ng (ev_flush_ng),
    .ev_recompute(ev_recompute),
    .ev_long_on  (ev_long_on),
    .ev_long_off (ev_long_off)
  );

  seg_base_bank #(.XLEN(XLEN)) u_seg (
    .clk          (clk),
    .rst_n        (rst_n),
    .base_we      (wr_fire && (wr_kind == K_BASE)),
    .base_sel     (wr_seg),
    .base_wdata   (wr_data),
    .in64         (in_64bit(efer_q[EF_LMA], csatr_q[AT_LONG])),
    .zero_legacy  (ev_long_on),
    .reload_legacy(ev_long_off),
    .base_q       (base_q),
    .eff_q        (eff_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cr0_q   <= CR0_RST;
      cr2_q   <= '0;
      cr3_q   <= '0;
      cr4_q   <= '0;
      cr8_q   <= '0;
      efer_q  <= '0;
      csatr_q <= '0;
      ssatr_q <= '0;
    end else begin
      if (ev_cr0_wr) begin
        cr0_q         <= wr_data;
        cr0_q[CR0_ET] <= 1'b1;
      end
      if (ev_lma_upd) efer_q[EF_LMA] <= wr_data[CR0_PG];
      if (wr_fire) begin
        case (wr_kind)
          K_CR: begin
            case (wr_cr)
              4'd2:    cr2_q <= wr_data;
              4'd3:    cr3_q <= wr_data;
              4'd4:    cr4_q <= wr_data;
              4'd8:    cr8_q <= wr_data;
              default: ;
            endcase
          end
          K_EFER:  efer_q  <= wr_data;
          K_CSATR: csatr_q <= wr_data;
          K_SSATR: ssatr_q <= wr_data;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_kind)
      K_CR: begin
        case (rd_cr)
          4'd0:    rd_data = cr0_q;
          4'd2:    rd_data = cr2_q;
          4'd3:    rd_data = cr3_q;
          4'd4:    rd_data = cr4_q;
          4'd8:    rd_data = cr8_q;
          default: rd_data = '0;
        endcase
      end
      K_EFER:  rd_data = efer_q;
      K_CSATR: rd_data = csatr_q;
      K_SSATR: rd_data = ssatr_q;
      K_BASE:  rd_data = base_q[rd_seg];
      K_EFF:   rd_data = eff_q[rd_seg];
      default: rd_data = '0;
    endcase
  end

  assign err             = wr_bad || rd_bad;
  assign flush_all       = ev_flush_all;
  assign flush_nonglobal = ev_flush_ng;
  assign mode_recompute  = ev_recompute;

  AST_ET_STUCK: assert property (@(posedge clk) disable iff (!rst_n) cr0_q[CR0_ET]); // R3
  AST_LMA_TRACKS_PG: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_idx == 6'd0 && (wr_data[CR0_PG] != cr0_q[CR0_PG]) && efer_q[EF_LME]) |=> (efer_q[EF_LMA] == cr0_q[CR0_PG])); // R1
  AST_PG_FLUSH_REAL: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_idx == 6'd0 && flush_all) |=> (cr0_q[CR0_PG] != $past(cr0_q[CR0_PG]))); // R2
  AST_CR4_FLUSH_REAL: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_idx == 6'd4 && flush_all) |=> ({cr4_q[CR4_PGE], cr4_q[CR4_PAE], cr4_q[CR4_PSE]} != $past({cr4_q[CR4_PGE], cr4_q[CR4_PAE], cr4_q[CR4_PSE]}))); // R5
  AST_CR3_NG: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_idx == 6'd3) |-> (flush_nonglobal && !flush_all)); // R4
  AST_BAD_WR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) wr_bad |=> ($stable(cr0_q) && $stable(cr4_q) && $stable(efer_q) && $stable(csatr_q) && $stable(base_q) && $stable(eff_q))); // R9
  AST_BAD_WR_QUIET: assert property (@(posedge clk) disable iff (!rst_n) wr_bad |-> !(flush_all || flush_nonglobal || mode_recompute)); // R9
  AST_BAD_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) rd_bad |-> (rd_data == '0)); // R9
endmodule

// File: tb/tb_cr_side_effect_unit.sv
`timescale 1ns/1ps
module tb_cr_side_effect_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [63:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [5:0]  rd_idx = '0;
  logic [63:0] rd_data;
  logic        err, flush_all, flush_nonglobal, mode_recompute;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic s_fa, s_ng, s_rc, s_err;

  always #2.5 clk = ~clk;

  cr_side_effect_unit #(.XLEN(64)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data), .err(err),
    .flush_all(flush_all), .flush_nonglobal(flush_nonglobal), .mode_recompute(mode_recompute)
  );

  function automatic bit can_write(int i);
    return (i == 0 || i == 2 || i == 3 || i == 4 || i == 8 || i == 16 || i == 17 || i == 18 || (i >= 24 && i <= 31));
  endfunction

  function automatic bit can_read(int i);
    return can_write(i) || (i >= 32 && i <= 39);
  endfunction

  function automatic logic [63:0] pat_b(int i);
    return 64'hA5A5_0000_0000_0000 + 64'(i) * 64'h1111 + 64'd1;
  endfunction

  function automatic logic [63:0] pat_c(int i);
    return 64'h0BAD_0000_0000_0F00 + 64'(i);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int idx, logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 6'(idx); wr_data = d;
    #1;
    s_fa = flush_all; s_ng = flush_nonglobal; s_rc = mode_recompute; s_err = err;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(int idx, output logic [63:0] d, output logic e);
    rd_en = 1'b1; rd_idx = 6'(idx);
    #1;
    d = rd_data; e = err;
    rd_en = 1'b0;
    #1;
  endtask

  initial begin
    logic [63:0] v;
    logic e;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;

    // R10 / R3 / R9: reset values and read legality over all indexes
    for (int i = 0; i < 64; i++) begin
      rd(i, v, e);
      chk("R9 read err", 64'(e), 64'(!can_read(i)));
      chk("R10 reset read", v, (i == 0) ? 64'h10 : 64'h0);
    end

    // R9: every illegal write index flags err, pulses nothing
    for (int i = 0; i < 64; i++) begin
      if (!can_write(i)) begin
        wr(i, '1);
        chk("R9 write err", 64'(s_err), 64'd1);
        chk("R9 no pulses", {61'd0, s_fa, s_ng, s_rc}, 64'd0);
      end
    end
    for (int i = 0; i < 64; i++) begin
      rd(i, v, e);
      chk("R9 state frozen", v, (i == 0) ? 64'h10 : 64'h0);
    end

    // R3 / R8: CR0 write without PG
    wr(0, 64'h1);
    chk("R8 cr0 recompute", 64'(s_rc), 64'd1);
    chk("R2 no pg flip", 64'(s_fa), 64'd0);
    rd(0, v, e); chk("R3 et forced", v, 64'h11);

    wr(16, 64'h100);
    chk("R8 efer no recompute", 64'(s_rc), 64'd0);
    rd(16, v, e); chk("R10 efer readback", v, 64'h100);

    // R1 / R2: paging on with long mode enabled
    wr(0, 64'h8000_0001);
    chk("R2 pg on flush", 64'(s_fa), 64'd1);
    rd(16, v, e); chk("R1 lma set", v, 64'h500);
    rd(0, v, e); chk("R3 cr0 readback", v, 64'h8000_0011);
    wr(0, 64'h8000_0001);
    chk("R2 pg same no flush", 64'(s_fa), 64'd0);

    // R4
    wr(3, 64'h0123_4000);
    chk("R4 ng pulse", 64'(s_ng), 64'd1);
    chk("R4 no full", 64'(s_fa), 64'd0);
    wr(3, 64'h0123_4000);
    chk("R4 ng pulse repeat", 64'(s_ng), 64'd1);

    // R5
    wr(4, 64'h20);  chk("R5 pae flip", 64'(s_fa), 64'd1);
    wr(4, 64'h120); chk("R5 other bit", 64'(s_fa), 64'd0);
    wr(4, 64'h1A0); chk("R5 pge flip", 64'(s_fa), 64'd1);
    wr(4, 64'h1B0); chk("R5 pse flip", 64'(s_fa), 64'd1);
    chk("R5 no ng", 64'(s_ng), 64'd0);

    // R7: outside 64-bit mode all effective bases follow
    for (int i = 0; i < 8; i++) wr(24 + i, pat_b(i));
    for (int i = 0; i < 8; i++) begin
      rd(32 + i, v, e); chk("R7 eff follows", v, pat_b(i));
    end

    // R6: long attribute rises
    wr(17, 64'h200);
    chk("R8 cs recompute", 64'(s_rc), 64'd1);
    for (int i = 0; i < 8; i++) begin
      rd(32 + i, v, e); chk("R6 long on eff", v, (i < 4) ? 64'h0 : pat_b(i));
      rd(24 + i, v, e); chk("R6 base kept", v, pat_b(i));
    end

    // R7: in 64-bit mode
    wr(24, pat_c(0));
    rd(32, v, e); chk("R7 legacy eff held", v, 64'h0);
    rd(24, v, e); chk("R7 base written", v, pat_c(0));
    wr(28, pat_c(4));
    rd(36, v, e); chk("R7 fs eff always", v, pat_c(4));

    // R6: no toggle
    wr(17, 64'h203);
    for (int i = 0; i < 4; i++) begin
      rd(32 + i, v, e); chk("R6 no toggle", v, 64'h0);
    end
    // R6: long attribute falls
    wr(17, 64'h0);
    for (int i = 0; i < 4; i++) begin
      rd(32 + i, v, e); chk("R6 reload", v, (i == 0) ? pat_c(0) : pat_b(i));
    end

    // R1: paging off clears LMA; with LME clear LMA untouched
    wr(0, 64'h1);
    chk("R2 pg off flush", 64'(s_fa), 64'd1);
    rd(16, v, e); chk("R1 lma cleared", v, 64'h100);
    wr(16, 64'h0);
    wr(0, 64'h8000_0001);
    chk("R2 pg flip no lme", 64'(s_fa), 64'd1);
    rd(16, v, e); chk("R1 lma untouched", v, 64'h0);

    // R8
    wr(18, 64'h5); chk("R8 ss recompute", 64'(s_rc), 64'd1);
    wr(2, 64'd77);
    chk("R8 cr2 quiet", {61'd0, s_fa, s_ng, s_rc}, 64'd0);
    wr(8, 64'd3);  chk("R8 cr8 quiet", 64'(s_rc), 64'd0);
    rd(2, v, e);  chk("R10 cr2", v, 64'd77);
    rd(8, v, e);  chk("R10 cr8", v, 64'd3);
    rd(18, v, e); chk("R10 ss attr", v, 64'd5);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule